// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

The arbiter collects up to twenty interrupt request sources and folds them onto ten vectors, several sources sharing one vector. Each vector carries a priority tier chosen from a restricted pair: the first two vectors choose between the top tier and the low tier, and the remaining eight choose between the middle tier and the low tier. The arbiter picks one winner among the pending vectors and presents its entry address to the processor. It also keeps track of which tier of service routine is running now.

A request is offered only when it outranks the routine now running. When the processor takes the offer with `irq_ack`, the tier of that routine is pushed onto a small stack of active tiers. When the routine finishes, the `irq_ret` strobe pops the stack, so the tier of the interrupted routine becomes current again. A global enable and a per-source enable decide whether a source can take part at all.

Top module: `vec_irq_arb`

## Requirements
- R1: When `irq_valid` is high, `irq_addr` equals 0x03 + 8 × v, where v is the 0-based index of the winning vector (0x03, 0x0B, … 0x4B).
- R2: Tier encoding is 1 = low, 2 = middle, 3 = top, 0 = none. `vec_hi[v]` = 0 gives the low tier. `vec_hi[v]` = 1 gives the top tier for vectors 0 and 1, and the middle tier for vectors 2 to 9. `irq_level` shows the tier of the offered vector.
- R3: Among pending vectors, the one with the highest tier wins.
- R4: Among pending vectors of equal tier, the one with the lowest index (lowest address) wins.
- R5: A source whose `src_en` bit is 0 never makes its vector pending.
- R6: Sources map to vectors as follows: sources 0 and 1 go to vectors 0 and 1. Sources 2 to 4 go to vector 2, sources 5 to 7 to vector 3, source 8 to vector 4, and sources 9 and 10 to vector 5. Source 11 goes to vector 6, source 12 to vector 7, sources 13 to 15 to vector 8, and sources 16 to 19 to vector 9. Any one enabled source makes its vector pending.
- R7: With `gie` at 0, `irq_valid` stays low.
- R8: `irq_valid` is high only when the winning tier is strictly above `act_level`. A pending request at the same or a lower tier is held off.
- R9: `irq_ack` while `irq_valid` is high (and `irq_ret` low) makes `act_level` equal the offered tier from the next cycle. `irq_ret` pops the tier stack, so `act_level` returns to the tier of the interrupted routine, or 0 if none was running.
- R10: Reset empties the tier stack (`act_level` = 0). `irq_ret` with an empty stack has no effect. `irq_ack` without `irq_valid` has no effect. When `irq_ack` and `irq_ret` arrive together, only the pop takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| src_req | input | 20 | Request lines of the sources |
| src_en | input | 20 | Per-source enable |
| vec_hi | input | 10 | Per-vector tier choice (0 = low, 1 = elevated) |
| irq_ack | input | 1 | Processor takes the offered vector |
| irq_ret | input | 1 | Return from the running routine |
| irq_valid | output | 1 | A vector is offered |
| irq_addr | output | 8 | Entry address of the offered vector |
| irq_level | output | 2 | Tier of the offered vector |
| act_level | output | 2 | Tier of the routine now running |

## Verification
The hardest state to reach is a three-deep nest: a low routine interrupted by a middle one, which is in turn interrupted by a top one. Requests of equal and lower tier must be pending and refused at every depth. A directed sequence builds this nest step by step, acknowledging a low vector, then a middle vector, then vector 0 at the top tier, while equal-tier requests stay asserted. It then unwinds the nest with return strobes. A long random run with frequent acknowledges and returns then reaches mixed nests, collisions of acknowledge and return, and returns on an empty stack. A behavioural model of the stack is compared with the design on every cycle.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
   localparam logic [1:0] LV_NONE = 2'd0;
   localparam logic [1:0] LV_LOW  = 2'd1;
   localparam logic [1:0] LV_MID  = 2'd2;
   localparam logic [1:0] LV_TOP  = 2'd3;

   localparam int MAP_W = 8;

   // default folding of 20 sources onto 10 vectors, 8 bits per entry
   function automatic logic [20*MAP_W-1:0] default_src_map();
      logic [20*MAP_W-1:0] m;
      int v;
      m = '0;
      for (int s = 0; s < 20; s++) begin
         if (s < 2)        v = s;
         else if (s < 5)   v = 2;
         else if (s < 8)   v = 3;
         else if (s == 8)  v = 4;
         else if (s < 11)  v = 5;
         else if (s == 11) v = 6;
         else if (s == 12) v = 7;
         else if (s < 16)  v = 8;
         else              v = 9;
         m[s*MAP_W +: MAP_W] = MAP_W'(v);
      end
      return m;
   endfunction
endpackage

// File: rtl/vec_irq_gather.sv
module vec_irq_gather
   import vec_irq_pkg::*;
#(
   parameter int N_SRC = 20,
   parameter int N_VEC = 10,
   parameter logic [N_SRC*MAP_W-1:0] SRC_MAP = default_src_map()
) (
   input  logic [N_SRC-1:0] src_live,
   output logic [N_VEC-1:0] vec_req
);
   logic [N_VEC-1:0][N_SRC-1:0] hit;

   for (genvar v = 0; v < N_VEC; v++) begin : g_vec
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         if (int'(SRC_MAP[s*MAP_W +: MAP_W]) == v) begin : g_on
            assign hit[v][s] = src_live[s];
         end else begin : g_off
            assign hit[v][s] = 1'b0;
         end
      end
      assign vec_req[v] = |hit[v];
   end
endmodule

// File: rtl/vec_irq_pick.sv
module vec_irq_pick
   import vec_irq_pkg::*;
#(
   parameter int N_VEC  = 10,
   parameter int N_TOPV = 2,
   localparam int IDX_W = $clog2(N_VEC)
) (
   input  logic [N_VEC-1:0] vec_req,
   input  logic [N_VEC-1:0] vec_hi,
   output logic [IDX_W-1:0] win_idx,
   output logic [1:0]       win_lvl
);
   logic [N_VEC-1:0][1:0] lvl;

   for (genvar v = 0; v < N_VEC; v++) begin : g_lvl
      if (v < N_TOPV) begin : g_top
         assign lvl[v] = !vec_req[v] ? LV_NONE : (vec_hi[v] ? LV_TOP : LV_LOW);
      end else begin : g_mid
         assign lvl[v] = !vec_req[v] ? LV_NONE : (vec_hi[v] ? LV_MID : LV_LOW);
      end
   end

   // ascending scan with strict compare keeps the lowest index on ties
   always_comb begin
      win_idx = '0;
      win_lvl = LV_NONE;
      for (int v = 0; v < N_VEC; v++) begin
         if (lvl[v] > win_lvl) begin
            win_lvl = lvl[v];
            win_idx = IDX_W'(v);
         end
      end
   end
endmodule

// File: rtl/vec_irq_lvl_stack.sv
module vec_irq_lvl_stack
   import vec_irq_pkg::*;
#(
   parameter int DEPTH = 3,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       push,
   input  logic       pop,
   input  logic [1:0] push_lvl,
   output logic [1:0] top_lvl
);
   logic [DEPTH-1:0][1:0] slot_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  do_pop, do_push;

   assign do_pop  = pop && (cnt_q != '0);
   assign do_push = push && !pop && (cnt_q != CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         slot_q <= '0;
      end else if (do_pop) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (do_push) begin
         slot_q[cnt_q] <= push_lvl;
         cnt_q         <= cnt_q + 1'b1;
      end
   end

   assign top_lvl = (cnt_q == '0) ? LV_NONE : slot_q[cnt_q - 1'b1];
endmodule

// File: rtl/vec_irq_arb.sv
module vec_irq_arb
   import vec_irq_pkg::*;
#(
   parameter int N_SRC    = 20,
   parameter int N_VEC    = 10,
   parameter int N_TOPV   = 2,
   parameter int DEPTH    = 3,
   parameter int ADDR_W   = 8,
   parameter int VEC_BASE = 3,
   parameter int VEC_STEP = 8,
   parameter logic [N_SRC*MAP_W-1:0] SRC_MAP = default_src_map(),
   localparam int IDX_W = $clog2(N_VEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gie,
   input  logic [N_SRC-1:0]  src_req,
   input  logic [N_SRC-1:0]  src_en,
   input  logic [N_VEC-1:0]  vec_hi,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_valid,
   output logic [ADDR_W-1:0] irq_addr,
   output logic [1:0]        irq_level,
   output logic [1:0]        act_level
);
   if (DEPTH < 3) begin : g_bad_depth
      $error("tier stack needs at least three slots");
   end
   if (VEC_BASE + VEC_STEP * (N_VEC - 1) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vector addresses do not fit ADDR_W");
   end
   if (N_TOPV > N_VEC) begin : g_bad_topv
      $error("N_TOPV exceeds N_VEC");
   end

   logic [N_VEC-1:0] vec_req;
   logic [IDX_W-1:0] win_idx;
   logic [1:0]       win_lvl;
   logic [1:0]       top_lvl;

   vec_irq_gather #(.N_SRC(N_SRC), .N_VEC(N_VEC), .SRC_MAP(SRC_MAP)) gather_i (
      .src_live (src_req & src_en),
      .vec_req  (vec_req)
   );

   vec_irq_pick #(.N_VEC(N_VEC), .N_TOPV(N_TOPV)) pick_i (
      .vec_req (vec_req),
      .vec_hi  (vec_hi),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   vec_irq_lvl_stack #(.DEPTH(DEPTH)) stack_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (irq_ack && irq_valid),
      .pop      (irq_ret),
      .push_lvl (win_lvl),
      .top_lvl  (top_lvl)
   );

   assign irq_valid = gie && (win_lvl > top_lvl);
   assign irq_level = irq_valid ? win_lvl : LV_NONE;
   assign irq_addr  = ADDR_W'(VEC_BASE + VEC_STEP * int'(win_idx));
   assign act_level = top_lvl;
endmodule

// File: rtl/vec_irq_arb_chk.sv
module vec_irq_arb_chk #(
   parameter int N_SRC  = 20,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gie,
   input logic [N_SRC-1:0]  src_req,
   input logic [N_SRC-1:0]  src_en,
   input logic              irq_ack,
   input logic              irq_ret,
   input logic              irq_valid,
   input logic [ADDR_W-1:0] irq_addr,
   input logic [1:0]        irq_level,
   input logic [1:0]        act_level
);
   assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_addr[2:0] == 3'b011);

   assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_req & src_en) == '0) |-> !irq_valid);

   assert_gie_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq_valid);

   assert_strict_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> irq_level > act_level);

   assert_push_tier_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_valid && !irq_ret) |=> act_level == $past(irq_level));

   assert_pop_lowers_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && act_level != 2'd0) |=> act_level < $past(act_level));

   assert_empty_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && act_level == 2'd0) |=> act_level == 2'd0);

   assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_ret && !(irq_ack && irq_valid)) |=> $stable(act_level));
endmodule

bind vec_irq_arb vec_irq_arb_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/vec_irq_arb_tb_top.sv
module vec_irq_arb_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gie = 1'b0;
   logic [19:0] src_req = '0;
   logic [19:0] src_en = '0;
   logic [9:0]  vec_hi = '0;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;
   logic        irq_valid;
   logic [7:0]  irq_addr;
   logic [1:0]  irq_level;
   logic [1:0]  act_level;

   int checks = 0;
   int errors = 0;
   string tag = "R10";
   int model_stk[$];

   always #(CLK_P/2) clk = ~clk;

   vec_irq_arb dut_i (
      .clk(clk), .rst_n(rst_n), .gie(gie), .src_req(src_req), .src_en(src_en),
      .vec_hi(vec_hi), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_valid(irq_valid), .irq_addr(irq_addr), .irq_level(irq_level),
      .act_level(act_level)
   );

   function automatic int src_to_vec(int s);
      case (s)
         0: return 0;
         1: return 1;
         2, 3, 4: return 2;
         5, 6, 7: return 3;
         8: return 4;
         9, 10: return 5;
         11: return 6;
         12: return 7;
         13, 14, 15: return 8;
         default: return 9;
      endcase
   endfunction

   function automatic int vec_tier(int v);
      if (!vec_hi[v]) return 1;
      return (v < 2) ? 3 : 2;
   endfunction

   function automatic int cur_tier();
      return (model_stk.size() == 0) ? 0 : model_stk[$];
   endfunction

   // returns winning vector or -1, tier through best
   function automatic int pick(output int best);
      int win;
      bit pend[10];
      win = -1;
      best = 0;
      for (int v = 0; v < 10; v++) pend[v] = 0;
      for (int s = 0; s < 20; s++) if (src_req[s] && src_en[s]) pend[src_to_vec(s)] = 1;
      for (int v = 0; v < 10; v++) if (pend[v] && vec_tier(v) > best) begin
         best = vec_tier(v);
         win = v;
      end
      return win;
   endfunction

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // compare, clock once, advance model
   task automatic cyc();
      int best, win;
      bit exp_valid;
      #1;
      win = pick(best);
      exp_valid = gie && (best > cur_tier());
      chk("act_level", int'(act_level), cur_tier());
      chk("irq_valid", int'(irq_valid), int'(exp_valid));
      if (exp_valid && irq_valid) begin
         chk("irq_addr", int'(irq_addr), 3 + 8 * win);
         chk("irq_level", int'(irq_level), best);
      end
      @(posedge clk);
      if (!rst_n) model_stk.delete();
      else if (irq_ret) begin
         if (model_stk.size() != 0) void'(model_stk.pop_back());
      end else if (irq_ack && exp_valid) model_stk.push_back(best);
      @(negedge clk);
   endtask

   task automatic only_src(int s);
      src_req = '0;
      src_req[s] = 1'b1;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL R10 watchdog actual 0 expected 1");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(7));
      @(negedge clk);
      repeat (3) cyc();
      rst_n = 1'b1;
      tag = "R10";
      cyc();

      // single sources across all vectors
      gie = 1'b1; src_en = '1;
      for (int s = 0; s < 20; s++) begin
         tag = (s % 2 == 0) ? "R1" : "R6";
         only_src(s);
         cyc();
      end

      tag = "R5";
      src_req = '1; src_en = '0; cyc();
      src_en = 20'h00100; cyc();          // only source 8 -> vector 4
      src_en = '1;

      tag = "R7";
      gie = 1'b0; cyc();
      irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
      gie = 1'b1;

      tag = "R2";
      for (int v = 0; v < 10; v++) begin
         vec_hi = '0; vec_hi[v] = 1'b1;
         src_req = '0;
         for (int s = 0; s < 20; s++) if (src_to_vec(s) == v) src_req[s] = 1'b1;
         cyc();
      end

      tag = "R3";
      vec_hi = 10'b10_0000_0000; src_req = '0; src_req[2] = 1; src_req[19] = 1; cyc();
      vec_hi = 10'b00_0000_0011; src_req = '0; src_req[1] = 1; src_req[19] = 1; cyc();
      vec_hi = 10'b11_1111_1110; src_req = '0; src_req[0] = 1; src_req[5] = 1; cyc();

      tag = "R4";
      vec_hi = '0; src_req = '0; src_req[18] = 1; src_req[9] = 1; src_req[6] = 1; cyc();
      vec_hi = '1; src_req = '0; src_req[0] = 1; src_req[1] = 1; cyc();
      vec_hi = 10'b11_1111_1100; src_req = '0; src_req[13] = 1; src_req[11] = 1; cyc();

      // build a three-deep nest
      tag = "R9";
      vec_hi = 10'b00_0000_1001; src_req = '0; src_req[9] = 1;   // vec5 low
      irq_ack = 1; cyc(); irq_ack = 0;
      tag = "R8";
      src_req[2] = 1; cyc();                                     // vec2 low held off
      src_req[5] = 1; cyc();                                     // vec3 mid offered
      tag = "R9";
      irq_ack = 1; cyc(); irq_ack = 0;
      tag = "R8";
      src_req[16] = 1; vec_hi[9] = 1; cyc();                     // vec9 mid held off
      src_req[0] = 1; cyc();                                     // vec0 top offered
      tag = "R9";
      irq_ack = 1; cyc(); irq_ack = 0;
      tag = "R8";
      src_req[1] = 1; vec_hi[1] = 1; cyc();                      // equal top held off
      tag = "R9";
      irq_ret = 1; cyc();
      src_req[0] = 0; src_req[1] = 0; cyc();
      cyc(); cyc(); irq_ret = 0;
      cyc();

      tag = "R10";
      src_req = '0; irq_ret = 1; cyc(); irq_ret = 0; cyc();
      irq_ack = 1; cyc(); irq_ack = 0; cyc();
      src_req[8] = 1; irq_ack = 1; irq_ret = 1; cyc();
      irq_ack = 0; irq_ret = 0; cyc();
      irq_ack = 1; cyc(); irq_ack = 0;
      rst_n = 0; cyc(); rst_n = 1; cyc();

      tag = "R8";
      for (int i = 0; i < 400; i++) begin
         src_req = 20'($urandom) & 20'($urandom);
         src_en  = 20'($urandom) | 20'($urandom);
         vec_hi  = 10'($urandom);
         gie     = ($urandom % 8) != 0;
         irq_ack = $urandom % 2;
         irq_ret = ($urandom % 5) == 0;
         cyc();
      end
      irq_ack = 0; irq_ret = 0;

      summary();
      $finish;
   end
endmodule